// File: doc/BRIEF.md
# Keyboard Command Sender for a Two-Wire Open-Drain Serial Port

This block lets on-chip logic send a command to a keyboard over the two-wire PS/2 bus and collect the keyboard's answer. A client presents a command byte, and optionally a parameter byte, on a one-cycle request. The block does the rest. It claims the bus by holding the clock line low, then clocks the byte out bit by bit on the edges the keyboard produces. It checks the keyboard's line acknowledge and then receives the reply frame. When the command carries a parameter, that byte goes out only after the keyboard has answered with the acknowledge code 0xFA.

Both bus lines are open-drain. The block never drives a line high. It only asserts a pull-low enable for the clock line or for the data line. The two line inputs come from the wired bus and are synchronised inside the block. Some replies have their own handling. A 0xFE reply makes the block send the last byte again, up to a set number of times. The echo command 0xEE is complete when 0xEE comes back. Every wait is guarded by a timer. A failed transaction ends with a one-cycle done pulse and a failure code. Interpreting key scancodes is left to other logic.

Top module: `kbd_cmd_host`

## Requirements
- R1: After reset both pull-low enables are 0, busy and done are 0 and fail_code is 0. Both pull-low enables stay 0 whenever busy is 0.
- R2: To start each byte, the clock pull-low is held for at least INHIBIT_CYCLES cycles. The data pull-low is asserted before the clock is released, and it is still asserted in the cycle the clock pull-low drops.
- R3: After the clock is released, the device's first eight falling clock edges each put the next data bit on the data line, least significant bit first. The ninth falling edge puts an odd-parity bit (the nine bits hold an odd number of ones). The tenth falling edge releases the data line as the stop bit.
- R4: At the eleventh falling edge the data line must be low (the line acknowledge). If it is high, the transaction ends with fail_code 2.
- R5: A reply is an 11-bit frame sampled on falling clock edges: a 0 start bit, eight data bits LSB first, odd parity, then a 1 stop bit. A valid frame updates reply_byte. A frame with a bad start, parity or stop bit ends the transaction with fail_code 3.
- R6: A parameter byte is sent only after the reply to the command is 0xFA. A reply to a command that is not 0xFA or 0xFE ends the transaction with fail_code 3 and sends no parameter. The reply to the parameter ends the transaction: fail_code 0 if it is 0xFA, 3 otherwise.
- R7: A 0xFE reply makes the block send the same byte again. Once MAX_RETRY resends have been used, a further 0xFE ends the transaction with fail_code 3 and reply_byte 0xFE.
- R8: Command 0xEE ends with fail_code 0 when the reply is 0xEE, and with fail_code 3 on any other reply except 0xFE.
- R9: If any waiting phase makes no progress (no falling clock edge and no phase change) for TIMEOUT_CYCLES cycles, both lines are released and done pulses with fail_code 1.
- R10: req_valid is accepted only while busy is 0. A request made while busy is ignored: no further transfer follows.
- R11: busy is 1 from the cycle after an accepted request until done. done is a one-cycle pulse, and busy is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_cmd | input | 8 | Command byte |
| req_has_arg | input | 1 | Command carries a parameter byte |
| req_arg | input | 8 | Parameter byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| reply_byte | output | 8 | Last valid byte received from the keyboard |
| fail_code | output | 2 | 0 ok, 1 timeout, 2 no line acknowledge, 3 bad or unexpected reply |
| kb_clk_in | input | 1 | Level of the bus clock line |
| kb_dat_in | input | 1 | Level of the bus data line |
| kb_clk_pull | output | 1 | Pull the bus clock line low |
| kb_dat_pull | output | 1 | Pull the bus data line low |

## Verification
The bench builds the block with INHIBIT_CYCLES = 20, TIMEOUT_CYCLES = 3000 and MAX_RETRY = 2. At these values a keyboard model that runs 40-cycle bit periods gets through whole multi-byte exchanges within a few thousand cycles. The stalled-device timeout and the point where a third 0xFE exhausts the resends both come up within one short run. The small inhibit count also lets the bench measure the hold time of the clock line against its bound exactly.

// File: rtl/kbd_cmd_pkg.sv
package kbd_cmd_pkg;

  localparam logic [7:0] KB_ACK    = 8'hFA;
  localparam logic [7:0] KB_RESEND = 8'hFE;
  localparam logic [7:0] KB_ECHO   = 8'hEE;

  typedef enum logic [1:0] {
    FC_NONE    = 2'd0,
    FC_TIMEOUT = 2'd1,
    FC_NOACK   = 2'd2,
    FC_REPLY   = 2'd3
  } fail_t;

  typedef enum logic [2:0] {
    TX_IDLE, TX_INH, TX_REQ, TX_BITS, TX_ACK, TX_SETTLE
  } tx_state_t;

  typedef enum logic [1:0] {
    H_IDLE, H_SEND, H_REPLY, H_GAP
  } host_state_t;

  // parity bit giving an odd count of ones over data plus parity
  function automatic logic odd_par(input logic [7:0] b);
    return ~(^b);
  endfunction

endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_raw,
  input  logic dat_raw,
  output logic clk_s,
  output logic dat_s,
  output logic clk_fall
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic              clk_prev;

  assign raw = {dat_raw, clk_raw};

  genvar g;
  generate
    for (g = 0; g < NLINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], raw[g]};
      end
      assign synced[g] = chain[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) clk_prev <= 1'b1;
    else     clk_prev <= synced[0];
  end

  assign clk_s    = synced[0];
  assign dat_s    = synced[1];
  assign clk_fall = clk_prev & ~synced[0];

endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       clk_fall,
  input  logic       dat_s,
  output logic       rx_valid,
  output logic       rx_bad,
  output logic [7:0] rx_byte
);
  localparam int FRAME_BITS = 11;

  logic [FRAME_BITS-2:0] sr;
  logic [3:0]            cnt;
  logic [FRAME_BITS-1:0] frame;
  logic                  good;

  assign frame = {dat_s, sr};
  assign good  = ~frame[0] & frame[10] & (^frame[9:1]);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt      <= '0;
      sr       <= '0;
      rx_valid <= 1'b0;
      rx_bad   <= 1'b0;
      if (rst) rx_byte <= '0;
    end else begin
      rx_valid <= 1'b0;
      rx_bad   <= 1'b0;
      if (clk_fall) begin
        if (cnt == 4'(FRAME_BITS - 1)) begin
          cnt      <= '0;
          rx_byte  <= frame[8:1];
          rx_valid <= good;
          rx_bad   <= ~good;
        end else begin
          sr  <= {dat_s, sr[FRAME_BITS-2:1]};
          cnt <= cnt + 4'd1;
        end
      end
    end
  end

  p_rx_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  p_rx_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && rx_bad));

endmodule

// File: rtl/kbd_frame_tx.sv
module kbd_frame_tx
  import kbd_cmd_pkg::*;
#(
  parameter int INHIBIT_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] byte_in,
  input  logic       abort,
  input  logic       clk_s,
  input  logic       dat_s,
  input  logic       clk_fall,
  output logic       clk_pull,
  output logic       dat_pull,
  output logic       tx_done,
  output logic       tx_nak
);
  localparam int IW      = $clog2(INHIBIT_CYCLES + 1);
  localparam int LAST_SH = 9;   // eight data bits then parity

  tx_state_t    st;
  logic [8:0]   sh;
  logic [IW-1:0] cnt;
  logic [3:0]   nbit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= TX_IDLE;
      sh       <= '0;
      cnt      <= '0;
      nbit     <= '0;
      clk_pull <= 1'b0;
      dat_pull <= 1'b0;
      tx_done  <= 1'b0;
      tx_nak   <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      tx_nak  <= 1'b0;
      if (abort) begin
        st       <= TX_IDLE;
        clk_pull <= 1'b0;
        dat_pull <= 1'b0;
      end else begin
        case (st)
          TX_IDLE: if (start) begin
            sh       <= {odd_par(byte_in), byte_in};
            cnt      <= IW'(INHIBIT_CYCLES - 1);
            clk_pull <= 1'b1;
            st       <= TX_INH;
          end
          TX_INH: begin
            if (cnt == '0) begin
              dat_pull <= 1'b1;
              st       <= TX_REQ;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          TX_REQ: begin
            clk_pull <= 1'b0;
            nbit     <= '0;
            st       <= TX_BITS;
          end
          TX_BITS: if (clk_fall) begin
            if (nbit == 4'(LAST_SH)) begin
              dat_pull <= 1'b0;
              st       <= TX_ACK;
            end else begin
              dat_pull <= ~sh[0];
              sh       <= sh >> 1;
              nbit     <= nbit + 4'd1;
            end
          end
          TX_ACK: if (clk_fall) begin
            if (!dat_s) st <= TX_SETTLE;
            else begin
              tx_nak <= 1'b1;
              st     <= TX_IDLE;
            end
          end
          TX_SETTLE: if (clk_s && dat_s) begin
            tx_done <= 1'b1;
            st      <= TX_IDLE;
          end
          default: st <= TX_IDLE;
        endcase
      end
    end
  end

  p_clk_free_bits_r3: assert property (@(posedge clk) disable iff (rst)
    (st == TX_BITS || st == TX_ACK || st == TX_SETTLE) |-> !clk_pull);
  p_data_before_release_r2: assert property (@(posedge clk) disable iff (rst)
    ($fell(clk_pull) && !$past(abort)) |-> dat_pull);
  p_stop_released_r4: assert property (@(posedge clk) disable iff (rst)
    (st == TX_ACK) |-> !dat_pull);

endmodule

// File: rtl/kbd_cmd_host.sv
module kbd_cmd_host
  import kbd_cmd_pkg::*;
#(
  parameter int INHIBIT_CYCLES = 5000,
  parameter int TIMEOUT_CYCLES = 750000,
  parameter int MAX_RETRY      = 3,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [7:0] req_cmd,
  input  logic       req_has_arg,
  input  logic [7:0] req_arg,
  output logic       busy,
  output logic       done,
  output logic [7:0] reply_byte,
  output logic [1:0] fail_code,
  input  logic       kb_clk_in,
  input  logic       kb_dat_in,
  output logic       kb_clk_pull,
  output logic       kb_dat_pull
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int RW = $clog2(MAX_RETRY + 1);

  host_state_t   st;
  logic [7:0]    cur_cmd, cur_arg, tx_byte;
  logic          has_arg, arg_phase, tx_start;
  logic [RW-1:0] retries;
  logic [TW-1:0] tmr;

  logic clk_s, dat_s, clk_fall;
  logic tx_done, tx_nak;
  logic rx_valid, rx_bad;
  logic [7:0] rx_byte;
  logic timeout_hit;

  // decision on a received reply
  logic  fin, to_gap, load_arg, bump_retry;
  fail_t fin_code;

  kbd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .clk_raw(kb_clk_in), .dat_raw(kb_dat_in),
    .clk_s(clk_s), .dat_s(dat_s), .clk_fall(clk_fall));

  kbd_frame_tx #(.INHIBIT_CYCLES(INHIBIT_CYCLES)) u_tx (
    .clk(clk), .rst(rst), .start(tx_start), .byte_in(tx_byte),
    .abort(timeout_hit), .clk_s(clk_s), .dat_s(dat_s), .clk_fall(clk_fall),
    .clk_pull(kb_clk_pull), .dat_pull(kb_dat_pull),
    .tx_done(tx_done), .tx_nak(tx_nak));

  kbd_frame_rx u_rx (
    .clk(clk), .rst(rst), .en(st == H_REPLY), .clk_fall(clk_fall),
    .dat_s(dat_s), .rx_valid(rx_valid), .rx_bad(rx_bad), .rx_byte(rx_byte));

  assign timeout_hit = (st != H_IDLE) && (tmr == TW'(TIMEOUT_CYCLES - 1));

  always_comb begin
    fin        = 1'b0;
    fin_code   = FC_NONE;
    to_gap     = 1'b0;
    load_arg   = 1'b0;
    bump_retry = 1'b0;
    if (st == H_REPLY) begin
      if (rx_bad) begin
        fin = 1'b1; fin_code = FC_REPLY;
      end else if (rx_valid) begin
        if (rx_byte == KB_RESEND) begin
          if (retries == RW'(MAX_RETRY)) begin
            fin = 1'b1; fin_code = FC_REPLY;
          end else begin
            to_gap = 1'b1; bump_retry = 1'b1;
          end
        end else if (arg_phase) begin
          fin = 1'b1;
          fin_code = (rx_byte == KB_ACK) ? FC_NONE : FC_REPLY;
        end else if (cur_cmd == KB_ECHO) begin
          fin = 1'b1;
          fin_code = (rx_byte == KB_ECHO) ? FC_NONE : FC_REPLY;
        end else if (rx_byte == KB_ACK) begin
          if (has_arg) begin
            to_gap = 1'b1; load_arg = 1'b1;
          end else begin
            fin = 1'b1;
          end
        end else begin
          fin = 1'b1; fin_code = FC_REPLY;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= H_IDLE;
      cur_cmd    <= '0;
      cur_arg    <= '0;
      tx_byte    <= '0;
      has_arg    <= 1'b0;
      arg_phase  <= 1'b0;
      tx_start   <= 1'b0;
      retries    <= '0;
      tmr        <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      reply_byte <= '0;
      fail_code  <= FC_NONE;
    end else begin
      done     <= 1'b0;
      tx_start <= 1'b0;
      if (st != H_IDLE) tmr <= clk_fall ? '0 : tmr + 1'b1;

      if (timeout_hit) begin
        done      <= 1'b1;
        busy      <= 1'b0;
        fail_code <= FC_TIMEOUT;
        st        <= H_IDLE;
      end else begin
        case (st)
          H_IDLE: if (req_valid) begin
            cur_cmd   <= req_cmd;
            cur_arg   <= req_arg;
            has_arg   <= req_has_arg;
            arg_phase <= 1'b0;
            retries   <= '0;
            tx_byte   <= req_cmd;
            tx_start  <= 1'b1;
            busy      <= 1'b1;
            tmr       <= '0;
            st        <= H_SEND;
          end
          H_SEND: begin
            if (tx_nak) begin
              done      <= 1'b1;
              busy      <= 1'b0;
              fail_code <= FC_NOACK;
              st        <= H_IDLE;
            end else if (tx_done) begin
              tmr <= '0;
              st  <= H_REPLY;
            end
          end
          H_REPLY: begin
            if (rx_valid) reply_byte <= rx_byte;
            if (fin) begin
              done      <= 1'b1;
              busy      <= 1'b0;
              fail_code <= fin_code;
              st        <= H_IDLE;
            end else if (to_gap) begin
              tmr <= '0;
              st  <= H_GAP;
              if (bump_retry) retries <= retries + 1'b1;
              if (load_arg) begin
                arg_phase <= 1'b1;
                retries   <= '0;
                tx_byte   <= cur_arg;
              end
            end
          end
          H_GAP: if (clk_s && dat_s) begin
            tx_start <= 1'b1;
            tmr      <= '0;
            st       <= H_SEND;
          end
          default: st <= H_IDLE;
        endcase
      end
    end
  end

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_lines_free_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!kb_clk_pull && !kb_dat_pull));
  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> $stable(cur_cmd));
  p_timeout_release_r9: assert property (@(posedge clk) disable iff (rst)
    (done && fail_code == FC_TIMEOUT) |-> (!kb_clk_pull && !kb_dat_pull));

endmodule

// File: tb/kbd_cmd_host_test.sv
module kbd_cmd_host_test;
  localparam int INH = 20;
  localparam int TMO = 3000;
  localparam int RETRY = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [7:0] req_cmd = '0, req_arg = '0;
  logic req_has_arg = 1'b0;
  logic busy, done;
  logic [7:0] reply_byte;
  logic [1:0] fail_code;
  logic kb_clk_pull, kb_dat_pull;
  logic dev_clk = 1'b0, dev_dat = 1'b0;
  logic kb_clk_w, kb_dat_w;

  assign kb_clk_w = !(kb_clk_pull || dev_clk);
  assign kb_dat_w = !(kb_dat_pull || dev_dat);

  always #5 clk = ~clk;

  kbd_cmd_host #(.INHIBIT_CYCLES(INH), .TIMEOUT_CYCLES(TMO), .MAX_RETRY(RETRY))
  uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_has_arg(req_has_arg), .req_arg(req_arg), .busy(busy), .done(done),
    .reply_byte(reply_byte), .fail_code(fail_code),
    .kb_clk_in(kb_clk_w), .kb_dat_in(kb_dat_w),
    .kb_clk_pull(kb_clk_pull), .kb_dat_pull(kb_dat_pull));

  typedef struct {
    int    code;
    bit    chk_rep;
    int    rep;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0, n_fail = 0, n_done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      n_done++;
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(fail_code == 2'(e.code), e.req, fail_code, e.code);
        if (e.chk_rep) chk(reply_byte == 8'(e.rep), e.req, reply_byte, e.rep);
        chk(!kb_clk_pull && !kb_dat_pull && !busy, "R9 R11 lines free at done",
            {kb_clk_pull, kb_dat_pull, busy}, 0);
      end
    end
  end

  task automatic send_req(input logic [7:0] c, input bit ha, input logic [7:0] a,
                          input int code, input bit cr, input int rep, input string req);
    exp_t e;
    e.code = code; e.chk_rep = cr; e.rep = rep; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    req_cmd = c; req_has_arg = ha; req_arg = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R11 busy after accept", busy, 1);
  endtask

  // device receives one host byte
  task automatic dev_rx(input logic [7:0] expb, input bit do_ack);
    int inh;
    logic [9:0] bits;
    inh = 0;
    while (!kb_clk_pull) @(negedge clk);
    while (kb_clk_pull) begin inh++; @(negedge clk); end
    chk(inh >= INH, "R2 inhibit length", inh, INH);
    chk(kb_dat_pull == 1'b1, "R2 data low at clock release", kb_dat_pull, 1);
    for (int i = 0; i < 10; i++) begin
      repeat (10) @(negedge clk);
      dev_clk = 1'b1;
      repeat (20) @(negedge clk);
      dev_clk = 1'b0;
      repeat (2) @(negedge clk);
      bits[i] = kb_dat_w;
      repeat (8) @(negedge clk);
    end
    chk(bits[7:0] == expb, "R3 data bits LSB first", bits[7:0], expb);
    chk((^bits[8:0]) == 1'b1, "R3 odd parity", bits[8], ~(^expb));
    chk(bits[9] == 1'b1, "R3 stop released", bits[9], 1);
    if (do_ack) dev_dat = 1'b1;
    repeat (10) @(negedge clk);
    dev_clk = 1'b1;
    repeat (20) @(negedge clk);
    dev_clk = 1'b0;
    repeat (5) @(negedge clk);
    dev_dat = 1'b0;
  endtask

  // device sends one reply frame
  task automatic dev_tx(input logic [7:0] b, input bit corrupt);
    logic [10:0] fr;
    fr = {1'b1, (~(^b)) ^ corrupt, b, 1'b0};
    repeat (30) @(negedge clk);
    for (int i = 0; i < 11; i++) begin
      dev_dat = !fr[i];
      repeat (10) @(negedge clk);
      dev_clk = 1'b1;
      repeat (20) @(negedge clk);
      dev_clk = 1'b0;
    end
    dev_dat = 1'b0;
  endtask

  task automatic wait_done(input int target);
    while (n_done < target) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic idle_window(input string req);
    bit seen;
    seen = 1'b0;
    repeat (400) begin
      @(negedge clk);
      if (kb_clk_pull || kb_dat_pull || busy) seen = 1'b1;
    end
    chk(!seen, req, seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_done, 9);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && fail_code == 2'd0 && !kb_clk_pull && !kb_dat_pull,
        "R1 reset state", {busy, done, fail_code, kb_clk_pull, kb_dat_pull}, 0);

    // R8 echo
    send_req(8'hEE, 1'b0, 8'h00, 0, 1'b1, 8'hEE, "R8 echo reply");
    dev_rx(8'hEE, 1'b1);
    dev_tx(8'hEE, 1'b0);
    wait_done(1);

    // R6 parameter after FA, with R10 request while busy
    send_req(8'hED, 1'b1, 8'h05, 0, 1'b1, 8'hFA, "R6 param sequence");
    fork
      begin
        dev_rx(8'hED, 1'b1);
        dev_tx(8'hFA, 1'b0);
        dev_rx(8'h05, 1'b1);
        dev_tx(8'hFA, 1'b0);
      end
      begin
        repeat (60) @(negedge clk);
        req_cmd = 8'hFF; req_has_arg = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
      end
    join
    wait_done(2);
    idle_window("R10 busy request ignored");

    // R7 resend once then proceed
    send_req(8'hF3, 1'b1, 8'h2A, 0, 1'b1, 8'hFA, "R7 resend then ok");
    dev_rx(8'hF3, 1'b1);
    dev_tx(8'hFE, 1'b0);
    dev_rx(8'hF3, 1'b1);
    dev_tx(8'hFA, 1'b0);
    dev_rx(8'h2A, 1'b1);
    dev_tx(8'hFA, 1'b0);
    wait_done(3);

    // R6 unexpected reply, no parameter
    send_req(8'hED, 1'b1, 8'h07, 3, 1'b1, 8'hEE, "R6 unexpected reply");
    dev_rx(8'hED, 1'b1);
    dev_tx(8'hEE, 1'b0);
    wait_done(4);
    idle_window("R6 no parameter after non-ack");

    // R7 resends exhausted
    send_req(8'hFF, 1'b0, 8'h00, 3, 1'b1, 8'hFE, "R7 retries exhausted");
    for (int k = 0; k <= RETRY; k++) begin
      dev_rx(8'hFF, 1'b1);
      dev_tx(8'hFE, 1'b0);
    end
    wait_done(5);

    // R4 missing line acknowledge
    send_req(8'hEE, 1'b0, 8'h00, 2, 1'b0, 0, "R4 no line ack");
    dev_rx(8'hEE, 1'b0);
    wait_done(6);

    // R9 stalled device
    send_req(8'hEE, 1'b0, 8'h00, 1, 1'b0, 0, "R9 timeout");
    while (!kb_clk_pull) @(negedge clk);
    wait_done(7);

    // R5 bad parity reply
    send_req(8'hEE, 1'b0, 8'h00, 3, 1'b0, 0, "R5 bad parity");
    dev_rx(8'hEE, 1'b1);
    dev_tx(8'hEE, 1'b1);
    wait_done(8);

    // R5 plain command with good reply
    send_req(8'hF4, 1'b0, 8'h00, 0, 1'b1, 8'hFA, "R5 good reply");
    dev_rx(8'hF4, 1'b1);
    dev_tx(8'hFA, 1'b0);
    wait_done(9);

    chk(exp_q.size() == 0, "R11 all transactions done", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule